// File: doc/BRIEF.md
# Light-Load Burst Controller

This block sits in the digital core of a flyback switching controller and manages its lowest-power regime. While the converter runs normally, it watches two signs of a very light load: the feedback comparator says the regulation level is under the burst-entry level, and the external load-tracking counter has reached its top value of 7. When both hold without a break for a programmable blanking window, the block goes into burst mode. It raises its burst-active flag and drops the bias enable, so switching stops.

Inside burst mode, switching follows a hysteresis on feedback. When feedback climbs past the burst-on level, bias and switching come back. When it sinks under the burst-off level, they go off again. While switching is on, a free-running timer with a fixed period starts each gate pulse. A pulse ends at the first of two events: the current-sense peak flag, or half of the timer period. When feedback rises past the exit level, burst mode ends at once. A one-cycle pulse then tells the load-tracking counter to reload to 1. Other blocks use the burst-active flag to mask the protections that must not act during bursts.

Top module: `lightload_burst_ctrl`

## Requirements
- R1: After a synchronous reset, burst_active, gate_req and load_reset_pulse are 0 and bias_en is 1.
- R2: burst_active goes to 1 on the clock edge that is the BLANK_CYC-th consecutive edge at which fb_below_entry is 1 and load_count equals 7. It is still 0 one cycle earlier.
- R3: If either entry condition is missing at any edge, the blanking count restarts from zero. A full BLANK_CYC run of consecutive edges is then needed again.
- R4: On entry, bias_en goes to 0 in the same cycle. gate_req stays 0 until switching is enabled.
- R5: In burst mode, bias_en becomes 1 on the edge after fb_above_on is seen. It becomes 0 on the edge after fb_below_off is seen, and otherwise keeps its value. If both flags are seen together, fb_above_on wins.
- R6: gate_req is only ever 1 while burst_active is 1. While switching is enabled, a pulse starts every PERIOD_CYC cycles, and the first pulse starts in the same cycle that bias_en rises.
- R7: Without a current-sense event, each pulse lasts PERIOD_CYC/2 cycles.
- R8: If cs_over_limit is seen while gate_req is 1, gate_req is 0 from the next cycle. It stays 0 until the next period starts.
- R9: When fb_above_exit is seen in burst mode, burst_active and gate_req are 0 and bias_en is 1 from the next cycle.
- R10: On that exit, load_reset_pulse is 1 for exactly one cycle.
- R11: fb_above_exit seen outside burst mode has no effect: load_reset_pulse stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| fb_below_entry | input | 1 | Feedback under the burst-entry level |
| fb_above_on | input | 1 | Feedback over the burst switching-on level |
| fb_below_off | input | 1 | Feedback under the burst switching-off level |
| fb_above_exit | input | 1 | Feedback over the burst-exit level |
| cs_over_limit | input | 1 | Current sense over the burst peak limit |
| load_count | input | 3 | Load-tracking counter value (1 to 7) |
| burst_active | output | 1 | Burst regime is active |
| gate_req | output | 1 | Gate drive request |
| bias_en | output | 1 | Internal bias and switching enable |
| load_reset_pulse | output | 1 | One-cycle command to reload the load counter to 1 |

## Verification
The assertions assume that the comparator flags are already synchronous to clk and are plain levels, one sample per cycle. They also assume that load_count changes only between edges. They do not assume that the hysteresis flags are mutually exclusive, because the priority in R5 covers that case. The stimulus changes every input half a cycle away from the sampling edge and holds each flag for whole cycles. It sets fb_above_on and fb_below_off one at a time, and it drops the entry condition before exiting, so that the block does not re-enter straight after the exit being checked.

// File: rtl/lbc_pkg.sv
package lbc_pkg;
  typedef logic [2:0] load_cnt_t;
  localparam load_cnt_t LOAD_FULL = 3'd7;

  function automatic int cyc_from_ms(int clk_hz, int ms);
    return (clk_hz / 1000) * ms;
  endfunction

  function automatic int cyc_from_hz(int clk_hz, int hz);
    return clk_hz / hz;
  endfunction
endpackage

// File: rtl/lbc_entry_qual.sv
module lbc_entry_qual #(
  parameter int BLANK_CYC = 24000
) (
  input  logic clk,
  input  logic rst,
  input  logic cond,
  output logic qualify
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(BLANK_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign qualify = cond && (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst || !cond) begin
      cnt_q <= '0;
    end else if (cnt_q != CNT_LAST) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R3: a missing condition always restarts the window
  assert_window_restart_R3: assert property (@(posedge clk) disable iff (rst)
    !cond |=> cnt_q == '0);
endmodule

// File: rtl/lbc_pulse_timer.sv
module lbc_pulse_timer #(
  parameter int PERIOD_CYC = 19
) (
  input  logic clk,
  input  logic rst,
  input  logic en_next,
  input  logic cs_over,
  output logic gate
);
  localparam int PW = (PERIOD_CYC > 2) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(PERIOD_CYC - 1);
  localparam logic [PW-1:0] PH_HALF = PW'(PERIOD_CYC / 2);

  logic [PW-1:0] ph_q, ph_n;
  logic          cut_q, cut_n, gate_q;

  always_comb begin
    ph_n  = (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
    cut_n = (ph_n == '0) ? 1'b0 : (cut_q | (gate_q & cs_over));
  end

  always_ff @(posedge clk) begin
    if (rst || !en_next) begin
      ph_q   <= PH_LAST;
      cut_q  <= 1'b0;
      gate_q <= 1'b0;
    end else begin
      ph_q   <= ph_n;
      cut_q  <= cut_n;
      gate_q <= (ph_n < PH_HALF) && !cut_n;
    end
  end

  assign gate = gate_q;

  // R8: a peak-current hit while the gate is on ends the pulse
  assert_cs_cut_R8: assert property (@(posedge clk) disable iff (rst)
    gate_q && cs_over |=> !gate_q);
endmodule

// File: rtl/lightload_burst_ctrl.sv
module lightload_burst_ctrl
  import lbc_pkg::*;
#(
  parameter int CLK_HZ     = 1_000_000,
  parameter int BLANK_CYC  = cyc_from_ms(CLK_HZ, 24),
  parameter int PERIOD_CYC = cyc_from_hz(CLK_HZ, 52_000)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fb_below_entry,
  input  logic       fb_above_on,
  input  logic       fb_below_off,
  input  logic       fb_above_exit,
  input  logic       cs_over_limit,
  input  logic [2:0] load_count,
  output logic       burst_active,
  output logic       gate_req,
  output logic       bias_en,
  output logic       load_reset_pulse
);
  logic act_q, bias_q, pulse_q;
  logic act_n, bias_n;
  logic enter_now, exit_now, entry_cond;

  assign entry_cond = !act_q && fb_below_entry && (load_count == LOAD_FULL);
  assign exit_now   = act_q && fb_above_exit;

  lbc_entry_qual #(.BLANK_CYC(BLANK_CYC)) u_qual (
    .clk     (clk),
    .rst     (rst),
    .cond    (entry_cond),
    .qualify (enter_now)
  );

  always_comb begin
    if (exit_now)       act_n = 1'b0;
    else if (enter_now) act_n = 1'b1;
    else                act_n = act_q;

    if (!act_n)            bias_n = 1'b1;
    else if (enter_now)    bias_n = 1'b0;
    else if (fb_above_on)  bias_n = 1'b1;
    else if (fb_below_off) bias_n = 1'b0;
    else                   bias_n = bias_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= 1'b0;
      bias_q  <= 1'b1;
      pulse_q <= 1'b0;
    end else begin
      act_q   <= act_n;
      bias_q  <= bias_n;
      pulse_q <= exit_now;
    end
  end

  lbc_pulse_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .en_next (act_n && bias_n),
    .cs_over (cs_over_limit),
    .gate    (gate_req)
  );

  assign burst_active     = act_q;
  assign bias_en          = bias_q;
  assign load_reset_pulse = pulse_q;

  // R2: entry only after the light-load conditions were present
  assert_entry_cause_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_active) |-> $past(fb_below_entry) && ($past(load_count) == LOAD_FULL));
  // R4: switching is off at the moment of entry
  assert_entry_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(burst_active) |-> !bias_en && !gate_req);
  // R6: gate pulses exist only in burst mode
  assert_gate_in_burst_R6: assert property (@(posedge clk) disable iff (rst)
    gate_req |-> burst_active);
  // R9: normal operation keeps the bias on
  assert_bias_outside_R9: assert property (@(posedge clk) disable iff (rst)
    !burst_active |-> bias_en);
  // R10: every exit reloads the counter, for one cycle only
  assert_exit_reload_R10: assert property (@(posedge clk) disable iff (rst)
    $fell(burst_active) |-> load_reset_pulse);
  assert_reload_single_R10: assert property (@(posedge clk) disable iff (rst)
    load_reset_pulse |=> !load_reset_pulse);
endmodule

// File: tb/sim_lightload_burst_ctrl.sv
`timescale 1ns/1ps
module sim_lightload_burst_ctrl;
  localparam int B = 20;
  localparam int P = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fb_below_entry = 1'b0, fb_above_on = 1'b0, fb_below_off = 1'b0;
  logic fb_above_exit = 1'b0, cs_over_limit = 1'b0;
  logic [2:0] load_count = 3'd0;
  logic burst_active, gate_req, bias_en, load_reset_pulse;

  always #2 clk = ~clk;

  lightload_burst_ctrl #(.CLK_HZ(1_000_000), .BLANK_CYC(B), .PERIOD_CYC(P)) u0 (
    .clk(clk), .rst(rst),
    .fb_below_entry(fb_below_entry), .fb_above_on(fb_above_on),
    .fb_below_off(fb_below_off), .fb_above_exit(fb_above_exit),
    .cs_over_limit(cs_over_limit), .load_count(load_count),
    .burst_active(burst_active), .gate_req(gate_req),
    .bias_en(bias_en), .load_reset_pulse(load_reset_pulse)
  );

  // observed vector: {burst_active, gate_req, bias_en, load_reset_pulse}
  typedef struct {
    int         cyc;
    logic [3:0] val;
    logic [3:0] mask;
    string      tag;
  } exp_t;

  exp_t q[$];
  int cyc = 0;
  int n_run = 0;
  int n_fail = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic expect_out(int d, logic [3:0] v, logic [3:0] m, string tag);
    exp_t e;
    e.cyc = cyc + d; e.val = v; e.mask = m; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops due items and compares against the ports
  always @(negedge clk) begin
    exp_t e;
    logic [3:0] obs;
    obs = {burst_active, gate_req, bias_en, load_reset_pulse};
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      n_run++;
      if (e.cyc < cyc || ((obs & e.mask) != (e.val & e.mask))) begin
        n_fail++;
        $display("FAIL %s at cycle %0d: actual %b expected %b (mask %b)",
                 e.tag, cyc, obs & e.mask, e.val & e.mask, e.mask);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    step(1);
    expect_out(1, 4'b0010, 4'b1111, "R1");
    step(2);
    rst = 1'b0;
    expect_out(1, 4'b0010, 4'b1111, "R1");
    step(1);

    // R11: exit flag outside burst does nothing
    fb_above_exit = 1'b1;
    expect_out(1, 4'b0000, 4'b1001, "R11");
    expect_out(2, 4'b0000, 4'b1001, "R11");
    step(2);
    fb_above_exit = 1'b0;
    step(1);

    // R3: broken window restarts; R2: full window enters
    fb_below_entry = 1'b1;
    load_count = 3'd7;
    step(10);
    load_count = 3'd6;
    step(1);
    load_count = 3'd7;
    expect_out(B - 1, 4'b0000, 4'b1000, "R3");
    expect_out(B, 4'b1000, 4'b1110, "R2");
    step(B);

    // R4: quiet after entry
    expect_out(1, 4'b1000, 4'b1110, "R4");
    expect_out(3, 4'b1000, 4'b1110, "R4");
    step(3);

    // R5 on, R6 period, R7 half-period width
    fb_above_on = 1'b1;
    expect_out(1, 4'b1110, 4'b1110, "R5");
    expect_out(P / 2, 4'b0100, 4'b0100, "R7");
    expect_out(P / 2 + 1, 4'b0000, 4'b0100, "R7");
    expect_out(P, 4'b0000, 4'b0100, "R7");
    expect_out(P + 1, 4'b0100, 4'b0100, "R6");
    step(1);
    fb_above_on = 1'b0;
    step(P);

    // R8: current-sense cut, resumes next period
    cs_over_limit = 1'b1;
    expect_out(1, 4'b0000, 4'b0100, "R8");
    expect_out(3, 4'b0000, 4'b0100, "R8");
    expect_out(P, 4'b0100, 4'b0100, "R8");
    step(1);
    cs_over_limit = 1'b0;
    step(P - 1);

    // R5 off
    fb_below_off = 1'b1;
    expect_out(1, 4'b1000, 4'b1110, "R5");
    expect_out(4, 4'b0000, 4'b0110, "R5");
    step(1);
    fb_below_off = 1'b0;
    step(3);

    // re-enable, then exit mid-pulse: R9, R10
    fb_above_on = 1'b1;
    expect_out(1, 4'b1110, 4'b1110, "R6");
    step(1);
    fb_above_on = 1'b0;
    step(1);
    fb_above_exit = 1'b1;
    fb_below_entry = 1'b0;
    expect_out(1, 4'b0011, 4'b1111, "R9");
    expect_out(2, 4'b0010, 4'b1111, "R10");
    expect_out(3, 4'b0010, 4'b1111, "R10");
    step(3);
    fb_above_exit = 1'b0;
    step(2);

    if (q.size() > 0) begin
      n_fail += q.size();
      $display("FAIL all: actual %0d pending expected 0", q.size());
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule